// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical memory address. It keeps four segment base registers (code, data, stack and extra) that a simple write port loads. On every cycle the caller presents an access kind on a 3-bit code and the full set of candidate offsets: instruction pointer, source index, destination index, effective offset, stack pointer and base pointer. The access kind selects both the default segment and the offset. The block multiplies the segment by sixteen, adds the offset, and registers the result. The address appears on the cycle after the access is presented.

It belongs in the front end of a memory pipeline that already knows what kind of reference it is making and wants the default segment applied without extra decode. The sum wraps inside the 1 MB space. A code with no defined meaning produces address zero and raises an error flag for that cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: The address presented on `phys_addr` equals (segment × 16 + offset) modulo 2^20, computed from the inputs sampled at one rising clock edge and valid right after that edge.
- R2: Access code 0 (instruction fetch) uses the code segment with `ip_in` as offset.
- R3: Access codes 1 and 2 (data operand via source index / via destination index) use the data segment with `si_in` and `di_in` respectively.
- R4: Access code 3 (data operand addressed through BX or a 16-bit displacement, already reduced to one value) uses the data segment with `ea_in`.
- R5: Access code 4 (push or pop) uses the stack segment with `sp_in`.
- R6: Access code 5 (based stack access) uses the stack segment with `bp_in`.
- R7: Access code 6 (string destination) uses the extra segment with `di_in`.
- R8: A carry out of bit 19 is dropped. For example, segment 0xFFFF with offset 0xFFFF gives 0x0FFEF.
- R9: When `seg_we` is high at an edge, `seg_wdata` loads the register picked by `seg_sel` (0 code, 1 data, 2 stack, 3 extra). An access sampled at that same edge still sees the old value. Accesses from the next edge on see the new value.
- R10: Access code 7 drives `phys_addr` to zero with `acc_err` high. Every other code leaves `acc_err` low.
- R11: While `rst_n` is low, `phys_addr` and `acc_err` are zero and all four segment registers clear to zero.
- R12: Offset inputs that the current access code does not select have no effect on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_we | input | 1 | Segment register write enable |
| seg_sel | input | 2 | Segment register to write: 0 code, 1 data, 2 stack, 3 extra |
| seg_wdata | input | 16 | Value written to the selected segment register |
| acc_type | input | 3 | Access kind code (0..6 defined, 7 reserved) |
| ip_in | input | 16 | Instruction pointer offset |
| si_in | input | 16 | Source index offset |
| di_in | input | 16 | Destination index offset |
| ea_in | input | 16 | Effective offset for BX-based or displacement operands |
| sp_in | input | 16 | Stack pointer offset |
| bp_in | input | 16 | Base pointer offset |
| phys_addr | output | 20 | Registered 20-bit physical address |
| acc_err | output | 1 | Registered flag for a reserved access code |

## Verification
The bench builds the block with its default parameters: 16-bit segments and offsets and a 4-bit shift. At these sizes the largest bases and offsets are easy to drive, so the carry out of bit 19 can be exercised directly. Random segment writes interleave with random access codes, so a write and an access often fall on the same edge and the old-value rule is checked again and again. Every code, including the reserved one, comes up many times against a bench model of the four registers.

// File: rtl/seg_addr_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the segmented address generator.
// Assumes the access-kind code is 3 bits and exactly four segment registers.
package seg_addr_pkg;

    localparam int unsigned ACC_W  = 3;
    localparam int unsigned NSEG   = 4;
    localparam int unsigned SEL_W  = $clog2(NSEG);

    // Access kinds; the numeric codes are part of the block's interface.
    typedef enum logic [ACC_W-1:0] {
        ACC_FETCH       = 3'd0,
        ACC_DATA_SRC    = 3'd1,
        ACC_DATA_DST    = 3'd2,
        ACC_DATA_EA     = 3'd3,
        ACC_STACK       = 3'd4,
        ACC_STACK_BASED = 3'd5,
        ACC_STR_DST     = 3'd6,
        ACC_RSVD        = 3'd7
    } acc_kind_e;

    // Segment register indices; also the write-port select encoding.
    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

endpackage

// File: rtl/seg_regfile.sv
`timescale 1ns/1ps
// Module: seg_regfile
// Holds the segment base registers. One write per cycle. The new value
// is visible on seg_q only after the clock edge that wrote it.
// Assumes a synchronous active-low reset that clears all entries.
module seg_regfile #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned NREG  = 4,
    localparam int unsigned SW   = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SW-1:0]              wsel,
    input  logic [SEG_W-1:0]           wdata,
    output logic [NREG-1:0][SEG_W-1:0] seg_q
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Purpose: load entry g when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (we && (wsel == SW'(g))) begin
                seg_q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/seg_select.sv
`timescale 1ns/1ps
// Module: seg_select
// Decodes the access kind into a default segment index and the matching
// offset. Flags the reserved code. Purely combinational.
// Assumes the code map in seg_addr_pkg.
module seg_select
    import seg_addr_pkg::*;
#(
    parameter int unsigned OFF_W = 16
) (
    input  logic [ACC_W-1:0] acc_type,
    input  logic [OFF_W-1:0] ip_in,
    input  logic [OFF_W-1:0] si_in,
    input  logic [OFF_W-1:0] di_in,
    input  logic [OFF_W-1:0] ea_in,
    input  logic [OFF_W-1:0] sp_in,
    input  logic [OFF_W-1:0] bp_in,
    output seg_id_e          seg_idx,
    output logic [OFF_W-1:0] offset,
    output logic             illegal
);

    acc_kind_e kind;
    assign kind = acc_kind_e'(acc_type);

    // Purpose: map the access kind to its segment and offset source.
    always_comb begin
        seg_idx = SEG_DATA;
        offset  = '0;
        illegal = 1'b0;
        unique case (kind)
            ACC_FETCH:       begin seg_idx = SEG_CODE;  offset = ip_in; end
            ACC_DATA_SRC:    begin seg_idx = SEG_DATA;  offset = si_in; end
            ACC_DATA_DST:    begin seg_idx = SEG_DATA;  offset = di_in; end
            ACC_DATA_EA:     begin seg_idx = SEG_DATA;  offset = ea_in; end
            ACC_STACK:       begin seg_idx = SEG_STACK; offset = sp_in; end
            ACC_STACK_BASED: begin seg_idx = SEG_STACK; offset = bp_in; end
            ACC_STR_DST:     begin seg_idx = SEG_EXTRA; offset = di_in; end
            default:         begin illegal = 1'b1; end
        endcase
    end

endmodule

// File: rtl/seg_adder.sv
`timescale 1ns/1ps
// Module: seg_adder
// Forms (segment << SHIFT) + offset and keeps ADDR_W bits, so the carry
// out of the top bit is dropped and addresses wrap.
// Assumes OFF_W <= SEG_W + SHIFT.
module seg_adder #(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned SHIFT  = 4,
    localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base_sh;
    logic [ADDR_W-1:0] off_ext;

    // Purpose: align both operands to the address width, then add.
    always_comb begin
        base_sh = {seg, {SHIFT{1'b0}}};
        off_ext = ADDR_W'(off);
        addr    = base_sh + off_ext;
    end

endmodule

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
// Module: seg_addr_gen (top)
// Keeps four segment registers. Picks the default segment and offset from
// the access kind and registers the shifted-and-added physical address.
// The output is valid after the edge that sampled the access.
// A segment write shows up for accesses from the following edge on.
// Assumes a synchronous active-low reset.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned SHIFT  = 4,
    localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_we,
    input  logic [SEL_W-1:0]  seg_sel,
    input  logic [SEG_W-1:0]  seg_wdata,
    input  logic [ACC_W-1:0]  acc_type,
    input  logic [OFF_W-1:0]  ip_in,
    input  logic [OFF_W-1:0]  si_in,
    input  logic [OFF_W-1:0]  di_in,
    input  logic [OFF_W-1:0]  ea_in,
    input  logic [OFF_W-1:0]  sp_in,
    input  logic [OFF_W-1:0]  bp_in,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              acc_err
);

    logic [NSEG-1:0][SEG_W-1:0] seg_q;
    seg_id_e                    seg_idx;
    logic [OFF_W-1:0]           offset;
    logic                       illegal;
    logic [SEG_W-1:0]           seg_cur;
    logic [ADDR_W-1:0]          addr_d;

    seg_regfile #(
        .SEG_W (SEG_W),
        .NREG  (NSEG)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .wsel  (seg_sel),
        .wdata (seg_wdata),
        .seg_q (seg_q)
    );

    seg_select #(
        .OFF_W (OFF_W)
    ) u_sel (
        .acc_type (acc_type),
        .ip_in    (ip_in),
        .si_in    (si_in),
        .di_in    (di_in),
        .ea_in    (ea_in),
        .sp_in    (sp_in),
        .bp_in    (bp_in),
        .seg_idx  (seg_idx),
        .offset   (offset),
        .illegal  (illegal)
    );

    // Purpose: read the chosen segment from the pre-write register state.
    always_comb begin
        seg_cur = seg_q[seg_idx];
    end

    seg_adder #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_add (
        .seg  (seg_cur),
        .off  (offset),
        .addr (addr_d)
    );

    // Purpose: register the address and error flag; force zero on reserved code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr <= '0;
            acc_err   <= 1'b0;
        end else begin
            phys_addr <= illegal ? '0 : addr_d;
            acc_err   <= illegal;
        end
    end

endmodule

// File: rtl/seg_addr_chk.sv
`timescale 1ns/1ps
// Module: seg_addr_chk
// Checker for seg_addr_gen. It keeps its own shadow of the segment
// registers, built from the write port, and checks the registered
// address against it.
module seg_addr_chk #(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned SHIFT  = 4,
    localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seg_we,
    input logic [1:0]        seg_sel,
    input logic [SEG_W-1:0]  seg_wdata,
    input logic [2:0]        acc_type,
    input logic [OFF_W-1:0]  ip_in,
    input logic [OFF_W-1:0]  si_in,
    input logic [OFF_W-1:0]  di_in,
    input logic [OFF_W-1:0]  ea_in,
    input logic [OFF_W-1:0]  sp_in,
    input logic [OFF_W-1:0]  bp_in,
    input logic [ADDR_W-1:0] phys_addr,
    input logic              acc_err
);

    logic [SEG_W-1:0] sh [4];

    function automatic logic [ADDR_W-1:0] fold(input logic [SEG_W-1:0] s,
                                                input logic [OFF_W-1:0] o);
        return ADDR_W'({s, {SHIFT{1'b0}}}) + ADDR_W'(o);
    endfunction

    // Purpose: shadow copy of the segment registers from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) sh[i] <= '0;
        end else if (seg_we) begin
            sh[seg_sel] <= seg_wdata;
        end
    end

    AST_FETCH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type == 3'd0) |=> (phys_addr == $past(fold(sh[0], ip_in)))); // R2
    AST_DATA_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type == 3'd1) |=> (phys_addr == $past(fold(sh[1], si_in)))); // R3
    AST_DATA_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type == 3'd3) |=> (phys_addr == $past(fold(sh[1], ea_in)))); // R4
    AST_STACK_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type == 3'd4) |=> (phys_addr == $past(fold(sh[2], sp_in)))); // R5
    AST_STR_ES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type == 3'd6) |=> (phys_addr == $past(fold(sh[3], di_in)))); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type == 3'd7) |=> (acc_err && phys_addr == '0)); // R10
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type != 3'd7) |=> !acc_err); // R10

endmodule

bind seg_addr_gen seg_addr_chk #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT)
) u_chk (.*);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
// Bench for seg_addr_gen: directed corner cases plus seeded random traffic.
module sim_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_sel = '0;
    logic [15:0] seg_wdata = '0;
    logic [2:0]  acc_type = '0;
    logic [15:0] ip_in = '0, si_in = '0, di_in = '0, ea_in = '0, sp_in = '0, bp_in = '0;
    logic [19:0] phys_addr;
    logic        acc_err;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;
    logic [15:0] segm [4];

    always #4 clk = ~clk;

    seg_addr_gen u0 (.*);

    function automatic logic [19:0] mk(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic string tag_of(input logic [2:0] t);
        case (t)
            3'd0: return "R2";
            3'd1, 3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [19:0] a, input logic e);
        n_cmp++;
        if (phys_addr !== a || acc_err !== e) begin
            n_bad++;
            $display("FAIL %s: addr=%h err=%b expected addr=%h err=%b",
                     req, phys_addr, acc_err, a, e);
        end
    endtask

    // One access cycle, with an optional segment write on the same edge.
    task automatic acc(input logic [2:0] t, input logic [15:0] ip, si, di, ea, sp, bp,
                       input bit we, input logic [1:0] sel, input logic [15:0] wd,
                       input string req);
        logic [19:0] ea_exp;
        logic        er_exp;
        @(negedge clk);
        acc_type = t; ip_in = ip; si_in = si; di_in = di; ea_in = ea; sp_in = sp; bp_in = bp;
        seg_we = we; seg_sel = sel; seg_wdata = wd;
        er_exp = 1'b0;
        case (t)
            3'd0: ea_exp = mk(segm[0], ip);
            3'd1: ea_exp = mk(segm[1], si);
            3'd2: ea_exp = mk(segm[1], di);
            3'd3: ea_exp = mk(segm[1], ea);
            3'd4: ea_exp = mk(segm[2], sp);
            3'd5: ea_exp = mk(segm[2], bp);
            3'd6: ea_exp = mk(segm[3], di);
            default: begin ea_exp = '0; er_exp = 1'b1; end
        endcase
        if (we) segm[sel] = wd;
        @(posedge clk);
        #2;
        check(req, ea_exp, er_exp);
        seg_we = 1'b0;
    endtask

    initial begin
        int unsigned seed = 32'h0000_5EED;
        void'($urandom(seed));
        for (int i = 0; i < 4; i++) segm[i] = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R11", 20'h0, 1'b0);          // reset state of outputs
        @(negedge clk); rst_n = 1'b1;
        // R11: segments cleared by reset, so fetch address equals offset
        acc(3'd0, 16'h1234, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        // Load all segments (R9), each written with a concurrent access
        acc(3'd0, 16'h0010, 0, 0, 0, 0, 0, 1, 2'd0, 16'h1000, "R9");
        acc(3'd1, 0, 16'h0020, 0, 0, 0, 0, 1, 2'd1, 16'h2000, "R9");
        acc(3'd4, 0, 0, 0, 0, 16'h0030, 0, 1, 2'd2, 16'h3000, "R9");
        acc(3'd6, 0, 0, 16'h0040, 0, 0, 0, 1, 2'd3, 16'h4000, "R9");
        acc(3'd1, 0, 16'h0020, 0, 0, 0, 0, 0, 0, 0, "R9");   // now new value 0x20020
        // R2..R7 directed
        acc(3'd0, 16'hABCD, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        acc(3'd2, 0, 0, 16'h0777, 0, 0, 0, 0, 0, 0, "R3");
        acc(3'd3, 0, 0, 0, 16'h0101, 0, 0, 0, 0, 0, "R4");
        acc(3'd5, 0, 0, 0, 0, 0, 16'hFF00, 0, 0, 0, "R6");
        acc(3'd6, 0, 0, 16'h0002, 0, 0, 0, 0, 0, 0, "R7");
        // R12: unselected offsets changed, fetch address unchanged
        acc(3'd0, 16'h0055, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R12");
        acc(3'd0, 16'h0055, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 0, 0, 0, "R12");
        // R8: wraparound, seg FFFF + off FFFF -> 0FFEF
        acc(3'd4, 0, 0, 0, 0, 0, 0, 1, 2'd2, 16'hFFFF, "R9");
        acc(3'd4, 0, 0, 0, 0, 16'hFFFF, 0, 0, 0, 0, "R8");
        acc(3'd5, 0, 0, 0, 0, 0, 16'h0010, 0, 0, 0, "R8");   // 0xFFFF0+0x10 -> 0x00000
        // R10: reserved code, then back to legal
        acc(3'd7, 16'h1, 16'h2, 16'h3, 16'h4, 16'h5, 16'h6, 0, 0, 0, "R10");
        acc(3'd0, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        // Random traffic (R1 plus per-kind tags)
        for (int k = 0; k < 600; k++) begin
            logic [2:0] t;
            t = 3'($urandom);
            acc(t, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                16'($urandom), 16'($urandom), ($urandom % 4) == 0,
                2'($urandom), 16'($urandom), {"R1/", tag_of(t)});
        end
        // R11: reset again clears outputs and segments
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2;
        check("R11", 20'h0, 1'b0);
        for (int i = 0; i < 4; i++) segm[i] = '0;
        @(negedge clk); rst_n = 1'b1;
        acc(3'd6, 0, 0, 16'h0ABC, 0, 0, 0, 0, 0, 0, "R11");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(64'd8 * 64'd200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule